// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Alarm

This block is a real-time clock peripheral on a plain 32-bit register bus. It counts seconds in a 32-bit register that advances on a one-second tick input. It compares that count with an alarm register, and it raises one interrupt line for a per-second event and for an alarm event. It also holds a power-off request bit, a general storage register that software uses to mark the clock as already set up, and a trim register that is kept for the regulator settings.

Writes cross into a slow clock domain. The block models this with a busy window. After every accepted write, the ready bit in the control register stays low for a fixed number of cycles, and any write issued during that window is dropped. Software polls ready before each write. The two event flags are cleared by writing 0 to them, and writing 1 leaves them unchanged. A read-modify-write of the control register therefore keeps the flags as long as they are written back as 1.

Reads are combinational from `addr_i`. A write is a single-cycle strobe on `wr_en_i`. The register offsets are control 0x00, seconds 0x04, alarm 0x08, trim 0x0C, power-off 0x20 and marker 0x34. Any other offset reads 0.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset every register reads 0, except control, which reads 0x80 (only ready set). `irq_o` and `poweroff_o` are 0.
- R2: A write strobe while ready is 1 is accepted. Control bit 7 (ready) then reads 0 for exactly BUSY_CYCLES cycles and returns to 1. A write strobe while ready is 0 changes nothing.
- R3: The seconds register advances by one on each cycle with `tick_i` high while control bit 0 (run) is 1. It holds while run is 0, and it wraps from 0xFFFFFFFF to 0.
- R4: Writing offset 0x04 loads the seconds register. A write that coincides with a tick wins over the increment.
- R5: Control bit 6 (second flag) is set by every tick taken while run is 1.
- R6: A control write with 0 in bit 6 or bit 4 clears that flag. A 1 in those bits leaves the flag as it was. Bits 0, 2, 3 and 5 are stored as written, and bit 1 reads 0.
- R7: While control bit 2 (alarm enable) is 1 and the seconds register equals the alarm register (0x08), control bit 4 (alarm flag) is set. With alarm enable at 0, equality sets nothing.
- R8: `irq_o` is 1 exactly when (bit 6 and bit 5) or (bit 4 and bit 3) of control are 1.
- R9: Writing offset 0x20 with bit 0 set raises `poweroff_o`, which stays high until reset. Offset 0x20 reads that bit in bit 0. A write with bit 0 clear has no effect.
- R10: Offsets 0x08, 0x0C and 0x34 return the last 32-bit value written to them. Reads of an unmapped offset return 0, and writes to one change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per second |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | AW (6) | Byte offset for read and write |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt, level |
| poweroff_o | output | 1 | Power-off request, sticky |

## Verification
A wrong seconds or flag state shows on the read port one cycle after the edge that caused it. A wrong flag also shows on `irq_o` in that same cycle whenever its enable is set. A broken busy counter shows in two ways: as a ready pulse of the wrong length, and as a dropped or extra write that a later read-back exposes. An alarm compare error shows as a missing or stray alarm flag one cycle after the seconds value reaches the alarm value. Random sequences keep the alarm close to the count so that this case occurs often, and they are checked against a bench model after every operation.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [5:0] OFF_CTRL    = 6'h00;
  localparam logic [5:0] OFF_SEC     = 6'h04;
  localparam logic [5:0] OFF_ALARM   = 6'h08;
  localparam logic [5:0] OFF_TRIM    = 6'h0C;
  localparam logic [5:0] OFF_HIB     = 6'h20;
  localparam logic [5:0] OFF_MARK    = 6'h34;

  localparam int NSTORE = 3;
  // index 0 is the alarm compare value
  localparam logic [NSTORE-1:0][5:0] STORE_OFF = {OFF_MARK, OFF_TRIM, OFF_ALARM};

  localparam int B_RUN   = 0;
  localparam int B_AEN   = 2;
  localparam int B_AIE   = 3;
  localparam int B_AFLAG = 4;
  localparam int B_SIE   = 5;
  localparam int B_SFLAG = 6;
  localparam int B_READY = 7;

  typedef struct packed {
    logic sflag;
    logic sie;
    logic aflag;
    logic aie;
    logic aen;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/rtc_wr_gate.sv
module rtc_wr_gate #(
  parameter int BUSY_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_req_i,
  output logic ready_o,
  output logic fire_o
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  assign ready_o = (cnt_q == '0);
  assign fire_o  = wr_req_i & ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (fire_o)        cnt_q <= CW'(BUSY_CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic          tick_i,
  input  logic          run_i,
  output logic [DW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (load_i)          cnt_o <= load_val_i;
    else if (run_i && tick_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       sec_evt_i,
  input  logic       alarm_hit_i,
  output ctrl_t      ctrl_o,
  output logic       irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
    end else if (wr_i) begin
      ctrl_o.run   <= wdata_i[B_RUN];
      ctrl_o.aen   <= wdata_i[B_AEN];
      ctrl_o.aie   <= wdata_i[B_AIE];
      ctrl_o.sie   <= wdata_i[B_SIE];
      // write 0 clears, write 1 keeps; a new event wins
      ctrl_o.sflag <= (ctrl_o.sflag & wdata_i[B_SFLAG]) | sec_evt_i;
      ctrl_o.aflag <= (ctrl_o.aflag & wdata_i[B_AFLAG]) | alarm_hit_i;
    end else begin
      ctrl_o.sflag <= ctrl_o.sflag | sec_evt_i;
      ctrl_o.aflag <= ctrl_o.aflag | alarm_hit_i;
    end
  end

  assign irq_o = (ctrl_o.sflag & ctrl_o.sie) | (ctrl_o.aflag & ctrl_o.aie);
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
  import rtc_pkg::*;
#(
  parameter int DW          = 32,
  parameter int AW          = 6,
  parameter int BUSY_CYCLES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          poweroff_o
);
  logic          ready, wr_fire, wr_sec, wr_ctrl;
  logic [DW-1:0] sec_q;
  logic [DW-1:0] store_q [NSTORE];
  logic [DW-1:0] alarm_q;
  logic          alarm_hit, hib_q;
  ctrl_t         ctrl_q;

  rtc_wr_gate #(.BUSY_CYCLES(BUSY_CYCLES)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_req_i(wr_en_i),
    .ready_o (ready),
    .fire_o  (wr_fire)
  );

  assign wr_sec  = wr_fire && (addr_i == AW'(OFF_SEC));
  assign wr_ctrl = wr_fire && (addr_i == AW'(OFF_CTRL));

  rtc_sec_counter #(.DW(DW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (wr_sec),
    .load_val_i(wdata_i),
    .tick_i    (tick_i),
    .run_i     (ctrl_q.run),
    .cnt_o     (sec_q)
  );

  for (genvar i = 0; i < NSTORE; i++) begin : g_store
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      store_q[i] <= '0;
      else if (wr_fire && addr_i == AW'(STORE_OFF[i]))  store_q[i] <= wdata_i;
    end
  end

  assign alarm_q   = store_q[0];
  assign alarm_hit = ctrl_q.aen && (sec_q == alarm_q);

  rtc_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_ctrl),
    .wdata_i    (wdata_i[7:0]),
    .sec_evt_i  (tick_i && ctrl_q.run),
    .alarm_hit_i(alarm_hit),
    .ctrl_o     (ctrl_q),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                              hib_q <= 1'b0;
    else if (wr_fire && addr_i == AW'(OFF_HIB) && wdata_i[0]) hib_q <= 1'b1;
  end
  assign poweroff_o = hib_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(OFF_CTRL)) begin
      rdata_o[B_READY] = ready;
      rdata_o[B_SFLAG] = ctrl_q.sflag;
      rdata_o[B_SIE]   = ctrl_q.sie;
      rdata_o[B_AFLAG] = ctrl_q.aflag;
      rdata_o[B_AIE]   = ctrl_q.aie;
      rdata_o[B_AEN]   = ctrl_q.aen;
      rdata_o[B_RUN]   = ctrl_q.run;
    end else if (addr_i == AW'(OFF_SEC)) begin
      rdata_o = sec_q;
    end else if (addr_i == AW'(OFF_HIB)) begin
      rdata_o[0] = hib_q;
    end else begin
      for (int i = 0; i < NSTORE; i++)
        if (addr_i == AW'(STORE_OFF[i])) rdata_o = store_q[i];
    end
  end
endmodule

// File: rtl/rtc_sec_alarm_chk.sv
module rtc_sec_alarm_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          ready,
  input logic          wr_fire,
  input logic          wr_sec,
  input logic          run,
  input logic          aen,
  input logic          sflag,
  input logic          aflag,
  input logic [DW-1:0] sec_q,
  input logic [DW-1:0] alarm_q,
  input logic          irq_o,
  input logic          poweroff_o
);
  assert_busy_after_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire |=> !ready);
  assert_hold_while_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready && !tick_i) |=> $stable(sec_q));
  assert_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && tick_i && !wr_sec) |=> sec_q == $past(sec_q) + 1'b1);
  assert_stopped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !wr_sec) |=> $stable(sec_q));
  assert_sec_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && tick_i) |=> sflag);
  assert_alarm_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aen && sec_q == alarm_q) |=> aflag);
  assert_irq_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sflag || aflag));
  assert_poweroff_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poweroff_o |=> poweroff_o);
endmodule

bind rtc_sec_alarm rtc_sec_alarm_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .ready     (ready),
  .wr_fire   (wr_fire),
  .wr_sec    (wr_sec),
  .run       (ctrl_q.run),
  .aen       (ctrl_q.aen),
  .sflag     (ctrl_q.sflag),
  .aflag     (ctrl_q.aflag),
  .sec_q     (sec_q),
  .alarm_q   (alarm_q),
  .irq_o     (irq_o),
  .poweroff_o(poweroff_o)
);

// File: tb/rtc_sec_alarm_tb.sv
module rtc_sec_alarm_tb;
  localparam int BUSY = 4;
  localparam logic [5:0] A_CTRL = 6'h00, A_SEC = 6'h04, A_ALM = 6'h08,
                         A_TRIM = 6'h0C, A_HIB = 6'h20, A_MARK = 6'h34, A_NONE = 6'h10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tick = 1'b0, wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, poweroff;

  always #4 clk = ~clk;

  rtc_sec_alarm #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .poweroff_o(poweroff)
  );

  int n_chk = 0, n_err = 0, cyc = 0;

  logic [31:0] m_sec = 0, m_alm = 0, m_trim = 0, m_mark = 0;
  logic m_run = 0, m_aen = 0, m_aie = 0, m_sie = 0, m_sflag = 0, m_aflag = 0, m_hib = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_word();
    return {24'h0, 1'b1, m_sflag, m_sie, m_aflag, m_aie, m_aen, 1'b0, m_run};
  endfunction
  function automatic logic exp_irq();
    return (m_sflag & m_sie) | (m_aflag & m_aie);
  endfunction
  function automatic logic match();
    return m_aen && (m_sec == m_alm);
  endfunction

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic wait_ready();
    logic [31:0] v;
    do rd(A_CTRL, v); while (!v[7]);
  endtask

  task automatic model_write(logic [5:0] a, logic [31:0] d);
    case (a)
      A_SEC:  m_sec = d;
      A_ALM:  m_alm = d;
      A_TRIM: m_trim = d;
      A_MARK: m_mark = d;
      A_HIB:  m_hib = m_hib | d[0];
      A_CTRL: begin
        m_run = d[0]; m_aen = d[2]; m_aie = d[3]; m_sie = d[5];
        m_sflag = m_sflag & d[6]; m_aflag = m_aflag & d[4];
      end
      default: ;
    endcase
  endtask

  // accepted write; ends at the negedge after the capture edge
  task automatic do_write(logic [5:0] a, logic [31:0] d);
    logic pre;
    wait_ready();
    pre = match();
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    model_write(a, d);
    m_aflag = m_aflag | pre | match();
  endtask

  task automatic do_tick();
    logic pre;
    pre = match();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    if (m_run) begin m_sec = m_sec + 1; m_sflag = 1'b1; end
    m_aflag = m_aflag | pre | match();
  endtask

  task automatic check_all(string tag);
    logic [31:0] v;
    wait_ready();
    rd(A_CTRL, v); chk({tag, " R6 ctrl"}, v, ctrl_word());
    rd(A_SEC,  v); chk({tag, " R3 sec"}, v, m_sec);
    rd(A_ALM,  v); chk({tag, " R10 alarm"}, v, m_alm);
    rd(A_TRIM, v); chk({tag, " R10 trim"}, v, m_trim);
    rd(A_MARK, v); chk({tag, " R10 mark"}, v, m_mark);
    rd(A_HIB,  v); chk({tag, " R9 hib"}, v, {31'h0, m_hib});
    chk({tag, " R8 irq"}, {31'h0, irq}, {31'h0, exp_irq()});
    chk({tag, " R9 poweroff"}, {31'h0, poweroff}, {31'h0, m_hib});
  endtask

  initial begin
    logic [31:0] v;
    logic pre;
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl reset", v, 32'h80);
    rd(A_NONE, v); chk("R1 unmapped reset", v, 0);
    check_all("R1");

    // R2 busy window length and dropped write
    do_write(A_MARK, 32'hA5A5_0001);
    addr = A_CTRL;
    for (int i = 0; i <= BUSY; i++) begin
      #1 chk("R2 ready window", {31'h0, rdata[7]}, {31'h0, (i == BUSY)});
      if (i == 0) begin wr_en = 1'b1; addr = A_MARK; wdata = 32'hDEAD_BEEF; end
      @(negedge clk);
      wr_en = 1'b0; addr = A_CTRL;
    end
    rd(A_MARK, v); chk("R2 busy write dropped", v, 32'hA5A5_0001);

    // R3 stopped counter ignores ticks, running counter counts
    do_tick(); check_all("R3 stopped");
    do_write(A_CTRL, 32'h01);
    do_tick(); do_tick(); check_all("R3 run");
    // R3 wrap, R5 flag on wrap tick
    do_write(A_SEC, 32'hFFFF_FFFF);
    do_write(A_CTRL, 32'h01);
    do_tick();
    rd(A_SEC, v); chk("R3 wrap", v, 0);
    rd(A_CTRL, v); chk("R5 sflag", v[6], 1'b1);

    // R4 write coincident with tick
    wait_ready();
    pre = match();
    addr = A_SEC; wdata = 32'h0000_1000; wr_en = 1'b1; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    m_sec = 32'h1000; m_sflag = 1'b1; m_aflag = m_aflag | pre | match();
    rd(A_SEC, v); chk("R4 write beats tick", v, 32'h1000);
    check_all("R4");

    // R6 write 1 keeps flag, write 0 clears; R8 irq follows
    do_write(A_CTRL, 32'h61); check_all("R6 keep");
    chk("R8 irq sec", {31'h0, irq}, 32'h1);
    do_write(A_CTRL, 32'h21); check_all("R6 clear");
    chk("R8 irq low", {31'h0, irq}, 32'h0);

    // R7 alarm disabled then enabled
    do_write(A_ALM, 32'h1001);
    do_tick(); check_all("R7 disabled");
    rd(A_CTRL, v); chk("R7 no flag", v[4], 1'b0);
    do_write(A_CTRL, 32'h4D);
    check_all("R7 enabled");
    rd(A_CTRL, v); chk("R7 flag set", v[4], 1'b1);
    chk("R8 irq alarm", {31'h0, irq}, 32'h1);

    // R9 hibernate
    do_write(A_HIB, 32'hFFFF_FFFE); check_all("R9 zero write");
    do_write(A_HIB, 32'h1);        check_all("R9 raise");
    do_write(A_HIB, 32'h0);        check_all("R9 sticky");

    // R10 storage and unmapped offset
    do_write(A_TRIM, 32'h1234_5678);
    do_write(A_NONE, 32'hFFFF_FFFF);
    rd(A_NONE, v); chk("R10 unmapped read", v, 0);
    check_all("R10");

    // random sequences checked against the model
    for (int it = 0; it < 300; it++) begin
      case ($urandom_range(0, 5))
        0, 1: do_tick();
        2: do_write(A_SEC, m_alm - $urandom_range(0, 2));
        3: do_write(A_CTRL, $urandom & 32'hFF);
        4: do_write(A_ALM, m_sec + $urandom_range(0, 3));
        default: do_write(($urandom_range(0, 1) != 0) ? A_MARK : A_TRIM, $urandom);
      endcase
      check_all("RND");
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule